// File: doc/BRIEF.md
# Supply Overvoltage Reaction Controller

This block decides how the chip reacts when a supply comparator reports an overvoltage. It watches the comparator only while the operating mode is Init or Normal. Each detection in those modes sets a sticky status flag. When software has armed the reaction, the block also asks an external mode sequencer for a new mode, according to a configuration bit. With the bit at 1 it asks for a timed Restart: it drives the fault outputs, asks the software register to clear the arm bit, waits a fixed number of cycles, and then asks for a return to Normal even if the overvoltage is still present. With the bit at 0 it asks for Fail-safe. It stays there, with the fault outputs active, until an external wake or reset strobe releases it.

The comparator, the software register that holds the arm and configuration bits, and the mode sequencer are all outside the block. The block exchanges only levels and single-cycle strobes with them. The restart length, an optional synchronizer on the comparator input and the priority between setting and clearing the status flag are all parameters.

Top module: `ovr_react_ctrl`

## Requirements
- R1: A detection counts only while `mode_i` is 0 (Init) or 1 (Normal). In modes 2 (Stop), 3 (Restart), 4 (Fail-safe) and the unused codes 5 to 7, a detection leaves the status flag, the mode request and the fault output unchanged.
- R2: A detection in a watched mode sets `ov_status_o` one clock after it is sampled, whatever the arm bit is.
- R3: When armed with `cfg_restart_i`=1, a detection makes `mode_req_valid_o` high for one cycle with `mode_req_o`=3 (Restart) on the next clock, and `fault_out_o` goes high on that same clock.
- R4: Restart holds `fault_out_o` high for exactly RESTART_CYC cycles. On the following clock it issues a one-cycle request with `mode_req_o`=1 (Normal) and releases `fault_out_o`. This happens whether or not the overvoltage is still present.
- R5: A restart reaction pulses `react_en_clr_o` for one cycle, in the same cycle as the Restart request. A fail-safe reaction does not pulse it.
- R6: When armed with `cfg_restart_i`=0, a detection makes a one-cycle request with `mode_req_o`=4 (Fail-safe) on the next clock and raises `fault_out_o`.
- R7: With `react_en_i`=0, a detection sets only the status flag. No mode request is made and `fault_out_o` stays low.
- R8: Once the block has reacted with Fail-safe, it keeps `fault_out_o` high and makes no request until `fs_exit_i` is sampled high. One clock after that, `fault_out_o` is low.
- R9: `ov_status_o` stays set until `status_clr_i` is sampled high. With the default priority, a detection in the same cycle as the clear strobe leaves the flag set.
- R10: While a Restart or Fail-safe reaction is in progress, further detections start no new reaction and make no extra request.
- R11: After reset, `mode_req_valid_o`, `fault_out_o`, `ov_status_o` and `react_en_clr_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_det_i | input | 1 | Overvoltage comparator output, level |
| mode_i | input | 3 | Current operating mode from the sequencer |
| react_en_i | input | 1 | Arm bit: reaction enabled |
| cfg_restart_i | input | 1 | 1 selects Restart, 0 selects Fail-safe |
| status_clr_i | input | 1 | Write-one-to-clear strobe for the status flag |
| fs_exit_i | input | 1 | Wake or reset strobe that releases Fail-safe |
| mode_req_valid_o | output | 1 | One-cycle strobe qualifying `mode_req_o` |
| mode_req_o | output | 3 | Requested mode code |
| fault_out_o | output | 1 | Fault output activation |
| ov_status_o | output | 1 | Sticky overvoltage status flag |
| react_en_clr_o | output | 1 | One-cycle request to clear the arm bit |

## Verification
A wrong internal state shows up at the ports almost at once. A reaction state that is lost or entered by mistake changes `fault_out_o` on the very next clock. A restart counter that runs short or long moves the Normal request off its exact cycle, so the check that waits RESTART_CYC cycles sees it. A status flag that drops without a clear strobe, or that ignores the set-over-clear priority, reads back wrong on the next sample. The sweep covers every mode code, arm bit and configuration bit, so a wrong mode gate shows as a spurious or missing request within one cycle.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

   localparam int unsigned MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MODE_INIT     = 3'd0,
      MODE_NORMAL   = 3'd1,
      MODE_STOP     = 3'd2,
      MODE_RESTART  = 3'd3,
      MODE_FAILSAFE = 3'd4
   } ovr_mode_e;

   typedef enum logic [1:0] {
      RX_IDLE     = 2'd0,
      RX_RESTART  = 2'd1,
      RX_FAILSAFE = 2'd2
   } ovr_state_e;

   function automatic logic ovr_watched(input logic [MODE_W-1:0] m);
      return (m == MODE_INIT) || (m == MODE_NORMAL);
   endfunction

endpackage

// File: rtl/ovr_in_sync.sv
module ovr_in_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES > 4) begin : g_bad
      $error("ovr_in_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_i} ;
      end
      assign q_o = sh_q[STAGES-1];
   end
endmodule

// File: rtl/ovr_sticky.sv
module ovr_sticky #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic nxt;

   if (SET_WINS) begin : g_set_first
      always_comb begin
         if (set_i)      nxt = 1'b1;
         else if (clr_i) nxt = 1'b0;
         else            nxt = q_o;
      end
   end else begin : g_clr_first
      always_comb begin
         if (clr_i)      nxt = 1'b0;
         else if (set_i) nxt = 1'b1;
         else            nxt = q_o;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= nxt;
   end
endmodule

// File: rtl/ovr_delay_timer.sv
module ovr_delay_timer #(
   parameter int unsigned DELAY_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int unsigned CNT_W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

   if (DELAY_CYC < 1) begin : g_bad
      $error("ovr_delay_timer: DELAY_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   assign done_o = run_q && (cnt_q == LAST);
   assign busy_o = run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start_i) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end else if (done_o) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (run_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/ovr_react_ctrl.sv
module ovr_react_ctrl
   import ovr_pkg::*;
#(
   parameter int unsigned RESTART_CYC  = 16,
   parameter int unsigned SYNC_STAGES  = 0,
   parameter bit          STS_SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ov_det_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic             react_en_i,
   input  logic             cfg_restart_i,
   input  logic             status_clr_i,
   input  logic             fs_exit_i,
   output logic             mode_req_valid_o,
   output logic [MODE_W-1:0] mode_req_o,
   output logic             fault_out_o,
   output logic             ov_status_o,
   output logic             react_en_clr_o
);
   if (RESTART_CYC < 1) begin : g_bad_cyc
      $error("ovr_react_ctrl: RESTART_CYC must be at least 1");
   end

   logic       ov_q;
   logic       watched;
   logic       hit;
   logic       trig;
   logic       tmr_start;
   logic       tmr_busy;
   logic       tmr_done;
   ovr_state_e st_q;

   ovr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ov_det_i),
      .q_o   (ov_q)
   );

   assign watched   = ovr_watched(mode_i);
   assign hit       = ov_q && watched;
   assign trig      = hit && react_en_i && (st_q == RX_IDLE);
   assign tmr_start = trig && cfg_restart_i;

   ovr_sticky #(.SET_WINS(STS_SET_WINS)) u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (hit),
      .clr_i (status_clr_i),
      .q_o   (ov_status_o)
   );

   ovr_delay_timer #(.DELAY_CYC(RESTART_CYC)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (tmr_start),
      .busy_o  (tmr_busy),
      .done_o  (tmr_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q             <= RX_IDLE;
         mode_req_valid_o <= 1'b0;
         mode_req_o       <= MODE_NORMAL;
         react_en_clr_o   <= 1'b0;
      end else begin
         mode_req_valid_o <= 1'b0;
         react_en_clr_o   <= 1'b0;
         unique case (st_q)
            RX_IDLE: begin
               if (trig) begin
                  mode_req_valid_o <= 1'b1;
                  if (cfg_restart_i) begin
                     st_q           <= RX_RESTART;
                     mode_req_o     <= MODE_RESTART;
                     react_en_clr_o <= 1'b1;
                  end else begin
                     st_q       <= RX_FAILSAFE;
                     mode_req_o <= MODE_FAILSAFE;
                  end
               end
            end
            RX_RESTART: begin
               if (tmr_done || !tmr_busy) begin
                  st_q             <= RX_IDLE;
                  mode_req_valid_o <= 1'b1;
                  mode_req_o       <= MODE_NORMAL;
               end
            end
            RX_FAILSAFE: begin
               if (fs_exit_i) st_q <= RX_IDLE;
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   assign fault_out_o = (st_q != RX_IDLE);

endmodule

// File: rtl/ovr_react_chk.sv
module ovr_react_chk
   import ovr_pkg::*;
#(
   parameter int unsigned RESTART_CYC = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ov_q,
   input logic [MODE_W-1:0] mode_i,
   input logic             react_en_i,
   input logic             cfg_restart_i,
   input logic             status_clr_i,
   input logic             fs_exit_i,
   input logic [1:0]       st_q,
   input logic             mode_req_valid_o,
   input logic [MODE_W-1:0] mode_req_o,
   input logic             fault_out_o,
   input logic             ov_status_o,
   input logic             react_en_clr_o
);
   localparam int unsigned CW = $clog2(RESTART_CYC + 2);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic [CW-1:0] rs_cnt;
   logic          hit;
   logic          idle;

   assign hit  = ov_q && ovr_watched(mode_i);
   assign idle = (st_q == 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rs_cnt <= '0;
      else if (st_q == 2'd1)   rs_cnt <= (rs_cnt == CMAX) ? rs_cnt : rs_cnt + 1'b1;
      else                     rs_cnt <= '0;
   end

   p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !ovr_watched(mode_i)) |=> !fault_out_o);

   p_status_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> ov_status_o);

   p_restart_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && hit && react_en_i && cfg_restart_i) |=>
         (mode_req_valid_o && mode_req_o == MODE_RESTART && fault_out_o));

   p_restart_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req_valid_o && mode_req_o == MODE_NORMAL) |-> (rs_cnt == CW'(RESTART_CYC) && !fault_out_o));

   p_autoclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      react_en_clr_o |-> (mode_req_valid_o && mode_req_o == MODE_RESTART));

   p_fs_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && hit && react_en_i && !cfg_restart_i) |=>
         (mode_req_valid_o && mode_req_o == MODE_FAILSAFE && fault_out_o && !react_en_clr_o));

   p_no_react_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !react_en_i) |=> !mode_req_valid_o);

   p_fs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == 2'd2 && !fs_exit_i) |=> (st_q == 2'd2 && !mode_req_valid_o));

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_status_o && !status_clr_i) |=> ov_status_o);

   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_req_valid_o && mode_req_o == MODE_RESTART) |=> !mode_req_valid_o || RESTART_CYC == 1);

endmodule

bind ovr_react_ctrl ovr_react_chk #(.RESTART_CYC(RESTART_CYC)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .ov_q             (ov_q),
   .mode_i           (mode_i),
   .react_en_i       (react_en_i),
   .cfg_restart_i    (cfg_restart_i),
   .status_clr_i     (status_clr_i),
   .fs_exit_i        (fs_exit_i),
   .st_q             (st_q),
   .mode_req_valid_o (mode_req_valid_o),
   .mode_req_o       (mode_req_o),
   .fault_out_o      (fault_out_o),
   .ov_status_o      (ov_status_o),
   .react_en_clr_o   (react_en_clr_o)
);

// File: tb/ovr_react_ctrl_tb.sv
module ovr_react_ctrl_tb;
   localparam int unsigned DLY = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ov_det_i = 1'b0;
   logic [2:0] mode_i = 3'd1;
   logic       react_en_i = 1'b0;
   logic       cfg_restart_i = 1'b0;
   logic       status_clr_i = 1'b0;
   logic       fs_exit_i = 1'b0;
   logic       mode_req_valid_o;
   logic [2:0] mode_req_o;
   logic       fault_out_o;
   logic       ov_status_o;
   logic       react_en_clr_o;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   ovr_react_ctrl #(.RESTART_CYC(DLY)) u_dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .ov_det_i         (ov_det_i),
      .mode_i           (mode_i),
      .react_en_i       (react_en_i),
      .cfg_restart_i    (cfg_restart_i),
      .status_clr_i     (status_clr_i),
      .fs_exit_i        (fs_exit_i),
      .mode_req_valid_o (mode_req_valid_o),
      .mode_req_o       (mode_req_o),
      .fault_out_o      (fault_out_o),
      .ov_status_o      (ov_status_o),
      .react_en_clr_o   (react_en_clr_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ov_det_i = 1'b0; status_clr_i = 1'b0; fs_exit_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_case(input int m, input bit en, input bit cfg);
      bit mon, trig;
      mon  = (m == 0) || (m == 1);
      trig = mon && en;
      do_reset();
      chk("R11 reset fault", int'(fault_out_o), 0);
      chk("R11 reset status", int'(ov_status_o), 0);
      mode_i = 3'(m); react_en_i = en; cfg_restart_i = cfg; ov_det_i = 1'b1;
      @(negedge clk);
      ov_det_i = 1'b0;
      chk(mon ? "R2 status set" : "R1 status gated", int'(ov_status_o), int'(mon));
      chk(trig ? "R3/R6 request" : (mon ? "R7 no request" : "R1 no request"),
          int'(mode_req_valid_o), int'(trig));
      chk(trig ? "R3/R6 fault on" : "R7/R1 fault off", int'(fault_out_o), int'(trig));
      chk("R5 arm clear pulse", int'(react_en_clr_o), int'(trig && cfg));
      if (trig) chk(cfg ? "R3 restart code" : "R6 failsafe code",
                    int'(mode_req_o), cfg ? 3 : 4);
      if (trig && cfg) begin
         react_en_i = 1'b0;
         mode_i = 3'd3;
         ov_det_i = 1'b1;
         for (int j = 1; j < DLY; j++) begin
            if (j == 3) begin mode_i = 3'd1; react_en_i = 1'b1; end
            if (j == 4) begin mode_i = 3'd3; react_en_i = 1'b0; end
            @(negedge clk);
            chk("R4/R10 no early request", int'(mode_req_valid_o), 0);
            chk("R4 fault held", int'(fault_out_o), 1);
            chk("R5 pulse single", int'(react_en_clr_o), 0);
         end
         @(negedge clk);
         chk("R4 normal request", int'(mode_req_valid_o), 1);
         chk("R4 normal code", int'(mode_req_o), 1);
         chk("R4 fault released", int'(fault_out_o), 0);
         mode_i = 3'd1;
         @(negedge clk);
         chk("R4 no re-trigger when disarmed", int'(fault_out_o), 0);
         chk("R4 pulse ends", int'(mode_req_valid_o), 0);
         ov_det_i = 1'b0;
      end else if (trig) begin
         mode_i = 3'd1; react_en_i = 1'b1; cfg_restart_i = 1'b1;
         for (int j = 0; j < 5; j++) begin
            ov_det_i = j[0];
            @(negedge clk);
            chk("R8/R10 failsafe held", int'(fault_out_o), 1);
            chk("R8/R10 no request", int'(mode_req_valid_o), 0);
         end
         ov_det_i = 1'b0; react_en_i = 1'b0; fs_exit_i = 1'b1;
         @(negedge clk);
         fs_exit_i = 1'b0;
         chk("R8 failsafe released", int'(fault_out_o), 0);
      end
      if (mon) begin
         ov_det_i = 1'b0; mode_i = 3'd2;
         @(negedge clk);
         chk("R9 status sticky", int'(ov_status_o), 1);
         mode_i = 3'd1; react_en_i = 1'b0; ov_det_i = 1'b1; status_clr_i = 1'b1;
         @(negedge clk);
         chk("R9 set beats clear", int'(ov_status_o), 1);
         ov_det_i = 1'b0;
         @(negedge clk);
         status_clr_i = 1'b0;
         chk("R9 clear strobe", int'(ov_status_o), 0);
      end
   endtask

   initial begin
      do_reset();
      chk("R11 reset valid", int'(mode_req_valid_o), 0);
      chk("R11 reset arm clear", int'(react_en_clr_o), 0);
      for (int m = 0; m < 8; m++)
         for (int e = 0; e < 2; e++)
            for (int c = 0; c < 2; c++)
               run_case(m, e[0], c[0]);
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int n = 0; n < 100000; n++) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule